// File: doc/BRIEF.md
# Rename Map Checkpoint Unit

This block holds the speculative register alias table of an out-of-order core. Each architectural register maps to a physical register tag. Allocation updates the table one rename at a time. Two read ports return the current mapping combinationally.

Some branches receive a snapshot of the whole table when they are renamed. The number of snapshot slots is small, so a branch receives one only while a slot is free. When a branch that holds a snapshot resolves as mispredicted, the table is rolled back from that snapshot at once. The unit does not wait for the branch to become the oldest instruction in flight. A mispredicted branch without a snapshot only raises a pending flag. Such a branch is repaired later by the full flush from retirement, which reloads the table from a copy that is maintained by the retirement writes.

Slot age follows allocation order. A rollback releases the restored slot and every slot allocated after it. When several mispredictions compete, only the oldest one takes effect.

Top module: `rename_ckpt_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. `ckpt_avail` is 1, and `rec_done` and `pend_flush` are 0.
- R2: A rename write (`rn_we`) sets the mapping of `rn_arch` to `rn_ptag`. The new value is seen on the read ports from the next cycle. The read ports (port 0 in bits [4:0] of `rd_arch` and bits [5:0] of `rd_ptag`) show the table combinationally.
- R3: A checkpoint request (`cp_req`) made while a slot is free stores the table, as it stood at the start of that cycle, in the lowest free slot under branch ID `cp_bid`. `ckpt_avail` is 0 while all 4 slots are in use, and a request made then is ignored.
- R4: A resolution with `rs_vld`, `rs_mis` and `rs_ckpt` set, whose branch ID is held in a slot, restores that slot's table in the next cycle. `rec_done` is high for exactly that one cycle. A rename write or checkpoint request in the same cycle is ignored.
- R5: A restore releases its own slot and every slot allocated after it, in the same cycle.
- R6: A resolution with `rs_mis` = 0 for a held branch ID releases only that slot and leaves the table unchanged.
- R7: If two mispredictions with snapshots resolve in the same cycle, only the older one (the one allocated earlier) is restored. A resolution with `rs_ckpt` = 1 whose branch ID is no longer held (its slot was released) has no effect on the table, the slots or `rec_done`.
- R8: A misprediction with `rs_ckpt` = 0 sets `pend_flush` from the next cycle until a flush. The table is left unchanged and `rec_done` is not raised.
- R9: Retirement writes (`rt_we`) keep a committed copy of the table. A `flush` loads the table from that copy, releases all slots and clears `pend_flush`. A flush takes priority over any restore, rename write or checkpoint request in the same cycle, so none of them takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_we | input | 1 | Rename write enable |
| rn_arch | input | 5 | Architectural register being renamed |
| rn_ptag | input | 6 | New physical tag |
| cp_req | input | 1 | Checkpoint request for a branch |
| cp_bid | input | 4 | Branch ID of the checkpoint request |
| rs_vld | input | 2 | Resolution valid, one bit per port |
| rs_mis | input | 2 | Resolution is a misprediction, per port |
| rs_ckpt | input | 2 | Resolving branch was given a snapshot, per port |
| rs_bid | input | 8 | Branch IDs of the resolutions, port 0 in bits [3:0] |
| rt_we | input | 1 | Retirement write enable |
| rt_arch | input | 5 | Architectural register being retired |
| rt_ptag | input | 6 | Committed physical tag |
| flush | input | 1 | Full flush from retirement |
| rd_arch | input | 10 | Read addresses, port 0 in bits [4:0] |
| rd_ptag | output | 12 | Read data, port 0 in bits [5:0] |
| ckpt_avail | output | 1 | At least one snapshot slot is free |
| rec_done | output | 1 | One-cycle pulse after a snapshot restore |
| pend_flush | output | 1 | A misprediction without a snapshot awaits flush |

## Verification
The restore path is tested in several ways:
- A single misprediction, which shows the snapshot was taken before the later rename.
- A misprediction in the middle of three live snapshots. Counting the free slots afterwards tells releasing only the restored slot apart from releasing the younger slots as well.
- Two mispredictions in the same cycle on opposite ports. Here the younger one is on port 0, which separates age order from port priority.
- A late resolution of a branch whose slot was already released. This shows such a resolution is discarded.

Filling all four slots, and then making a correct resolution, separates releasing one slot from releasing all of them. A flush in the same cycle as a restore and a rename shows that the flush has priority.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int RCM_NARCH = 32;
  localparam int RCM_PTW   = 6;
  localparam int RCM_NSLOT = 4;
  localparam int RCM_BIDW  = 4;
  localparam int RCM_NRES  = 2;
  localparam int RCM_NRD   = 2;
endpackage

// File: rtl/rcm_slot_track.sv
module rcm_slot_track #(
  parameter int NSLOT = 4,
  parameter int BID_W = 4,
  parameter int NRES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_req,
  input  logic [BID_W-1:0]       alloc_bid,
  input  logic [NRES-1:0]        res_vld,
  input  logic [NRES-1:0]        res_mis,
  input  logic [NRES-1:0]        res_ckpt,
  input  logic [NRES*BID_W-1:0]  res_bid,
  input  logic                   flush,
  output logic                   avail,
  output logic                   alloc_fire,
  output logic [NSLOT-1:0]       alloc_oh,
  output logic                   restore_fire,
  output logic [NSLOT-1:0]       restore_oh
);
  logic [NSLOT-1:0] valid_q, valid_d;
  logic [BID_W-1:0] bid_q [NSLOT];
  logic [BID_W-1:0] bid_d [NSLOT];
  // older_q[i][j] is set when slot i was allocated before slot j
  logic [NSLOT-1:0] older_q [NSLOT];
  logic [NSLOT-1:0] older_d [NSLOT];
  logic [NSLOT-1:0] misp_hit, ok_hit, kill, surv, pick;
  logic             found;

  always_comb begin
    misp_hit = '0;
    ok_hit   = '0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int p = 0; p < NRES; p++) begin
        if (res_vld[p] && res_ckpt[p] && valid_q[s] &&
            bid_q[s] == res_bid[p*BID_W +: BID_W]) begin
          if (res_mis[p]) misp_hit[s] = 1'b1;
          else            ok_hit[s]   = 1'b1;
        end
      end
    end
  end

  // keep only the oldest mispredicting slot
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      restore_oh[s] = misp_hit[s] && !flush;
      for (int j = 0; j < NSLOT; j++) begin
        if (j != s && misp_hit[j] && older_q[j][s]) restore_oh[s] = 1'b0;
      end
    end
  end
  assign restore_fire = |restore_oh;

  always_comb begin
    kill = '0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int j = 0; j < NSLOT; j++) begin
        if (restore_oh[s] && (s == j || older_q[s][j])) kill[j] = 1'b1;
      end
    end
  end

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (!found && !valid_q[s]) begin
        pick[s] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign avail      = ~&valid_q;
  assign alloc_fire = alloc_req && !flush && !restore_fire && avail;
  assign alloc_oh   = alloc_fire ? pick : '0;
  assign surv       = valid_q & ~kill & ~ok_hit;

  always_comb begin
    valid_d = flush ? '0 : (surv | alloc_oh);
    bid_d   = bid_q;
    older_d = older_q;
    for (int k = 0; k < NSLOT; k++) begin
      if (alloc_oh[k]) begin
        bid_d[k] = alloc_bid;
        for (int j = 0; j < NSLOT; j++) begin
          older_d[j][k] = surv[j];
          older_d[k][j] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        bid_q[s]   <= '0;
        older_q[s] <= '0;
      end
    end else begin
      valid_q <= valid_d;
      if (alloc_fire) begin
        bid_q   <= bid_d;
        older_q <= older_d;
      end
    end
  end
endmodule

// File: rtl/rcm_map_store.sv
module rcm_map_store #(
  parameter int NARCH = 32,
  parameter int PTW   = 6,
  parameter int NSLOT = 4,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NARCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rn_we,
  input  logic [AW-1:0]        rn_arch,
  input  logic [PTW-1:0]       rn_ptag,
  input  logic                 rt_we,
  input  logic [AW-1:0]        rt_arch,
  input  logic [PTW-1:0]       rt_ptag,
  input  logic                 flush,
  input  logic                 snap_en,
  input  logic [NSLOT-1:0]     snap_oh,
  input  logic                 rest_en,
  input  logic [NSLOT-1:0]     rest_oh,
  input  logic [NRD*AW-1:0]    rd_arch,
  output logic [NRD*PTW-1:0]   rd_ptag
);
  logic [PTW-1:0] map_q [NARCH];
  logic [PTW-1:0] map_d [NARCH];
  logic [PTW-1:0] ret_q [NARCH];
  logic [PTW-1:0] ret_d [NARCH];
  logic [PTW-1:0] snap_q [NSLOT][NARCH];
  logic           map_en;

  assign map_en = flush || rest_en || rn_we;

  always_comb begin
    map_d = map_q;
    if (flush) begin
      map_d = ret_q;
    end else if (rest_en) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (rest_oh[s]) map_d = snap_q[s];
      end
    end else if (rn_we) begin
      map_d[rn_arch] = rn_ptag;
    end
  end

  always_comb begin
    ret_d = ret_q;
    if (rt_we) ret_d[rt_arch] = rt_ptag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) begin
        map_q[i] <= PTW'(i);
        ret_q[i] <= PTW'(i);
      end
    end else begin
      if (map_en) map_q <= map_d;
      if (rt_we)  ret_q <= ret_d;
    end
  end

  // snapshot storage: plain enabled registers, no reset needed
  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLOT; s++) begin
      if (snap_en && snap_oh[s]) snap_q[s] <= map_q;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_ptag[r*PTW +: PTW] = map_q[rd_arch[r*AW +: AW]];
  end
endmodule

// File: rtl/rename_ckpt_map.sv
module rename_ckpt_map
  import rcm_pkg::*;
#(
  parameter int NARCH = RCM_NARCH,
  parameter int PTW   = RCM_PTW,
  parameter int NSLOT = RCM_NSLOT,
  parameter int BID_W = RCM_BIDW,
  parameter int NRES  = RCM_NRES,
  parameter int NRD   = RCM_NRD,
  localparam int AW   = $clog2(NARCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rn_we,
  input  logic [AW-1:0]        rn_arch,
  input  logic [PTW-1:0]       rn_ptag,
  input  logic                 cp_req,
  input  logic [BID_W-1:0]     cp_bid,
  input  logic [NRES-1:0]      rs_vld,
  input  logic [NRES-1:0]      rs_mis,
  input  logic [NRES-1:0]      rs_ckpt,
  input  logic [NRES*BID_W-1:0] rs_bid,
  input  logic                 rt_we,
  input  logic [AW-1:0]        rt_arch,
  input  logic [PTW-1:0]       rt_ptag,
  input  logic                 flush,
  input  logic [NRD*AW-1:0]    rd_arch,
  output logic [NRD*PTW-1:0]   rd_ptag,
  output logic                 ckpt_avail,
  output logic                 rec_done,
  output logic                 pend_flush
);
  logic [1:0]       rs_sync_q;
  logic             arst_n;
  logic             alloc_fire, rst_fire, pend_d, rn_ok;
  logic [NSLOT-1:0] alloc_oh, rst_oh;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_sync_q <= 2'b00;
    else        rs_sync_q <= {rs_sync_q[0], 1'b1};
  end
  assign arst_n = rs_sync_q[1];

  rcm_slot_track #(.NSLOT(NSLOT), .BID_W(BID_W), .NRES(NRES)) u_trk (
    .clk          (clk),
    .rst_n        (arst_n),
    .alloc_req    (cp_req),
    .alloc_bid    (cp_bid),
    .res_vld      (rs_vld),
    .res_mis      (rs_mis),
    .res_ckpt     (rs_ckpt),
    .res_bid      (rs_bid),
    .flush        (flush),
    .avail        (ckpt_avail),
    .alloc_fire   (alloc_fire),
    .alloc_oh     (alloc_oh),
    .restore_fire (rst_fire),
    .restore_oh   (rst_oh)
  );

  assign rn_ok = rn_we && !rst_fire && !flush;

  rcm_map_store #(.NARCH(NARCH), .PTW(PTW), .NSLOT(NSLOT), .NRD(NRD)) u_map (
    .clk     (clk),
    .rst_n   (arst_n),
    .rn_we   (rn_ok),
    .rn_arch (rn_arch),
    .rn_ptag (rn_ptag),
    .rt_we   (rt_we),
    .rt_arch (rt_arch),
    .rt_ptag (rt_ptag),
    .flush   (flush),
    .snap_en (alloc_fire),
    .snap_oh (alloc_oh),
    .rest_en (rst_fire),
    .rest_oh (rst_oh),
    .rd_arch (rd_arch),
    .rd_ptag (rd_ptag)
  );

  always_comb begin
    pend_d = pend_flush;
    if (flush)                             pend_d = 1'b0;
    else if (|(rs_vld & rs_mis & ~rs_ckpt)) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_flush <= 1'b0;
      rec_done   <= 1'b0;
    end else begin
      pend_flush <= pend_d;
      rec_done   <= rst_fire;
    end
  end
endmodule

// File: rtl/rcm_chk.sv
module rcm_chk #(
  parameter int AW    = 5,
  parameter int PTW   = 6,
  parameter int NRES  = 2,
  parameter int NRD   = 2
) (
  input logic                clk,
  input logic                arst_n,
  input logic                flush,
  input logic                rn_we,
  input logic [AW-1:0]       rn_arch,
  input logic [PTW-1:0]      rn_ptag,
  input logic [NRES-1:0]     rs_vld,
  input logic [NRES-1:0]     rs_mis,
  input logic [NRES-1:0]     rs_ckpt,
  input logic [NRD*AW-1:0]   rd_arch,
  input logic [NRD*PTW-1:0]  rd_ptag,
  input logic                ckpt_avail,
  input logic                rec_done,
  input logic                pend_flush,
  input logic                rst_fire
);
  a_r4_done_has_cause: assert property (@(posedge clk) disable iff (!arst_n)
    rec_done |-> $past((|(rs_vld & rs_mis & rs_ckpt)) && !flush));

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!arst_n)
    flush |=> (ckpt_avail && !pend_flush && !rec_done));

  a_r8_pend_set: assert property (@(posedge clk) disable iff (!arst_n)
    ((|(rs_vld & rs_mis & ~rs_ckpt)) && !flush) |=> pend_flush);

  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!arst_n)
    (pend_flush && !flush) |=> pend_flush);

  a_r2_write_seen: assert property (@(posedge clk) disable iff (!arst_n)
    (rn_we && !flush && !rst_fire) |=>
      ((rd_arch[AW-1:0] != $past(rn_arch)) || (rd_ptag[PTW-1:0] == $past(rn_ptag))));
endmodule

bind rename_ckpt_map rcm_chk #(.AW(AW), .PTW(PTW), .NRES(NRES), .NRD(NRD)) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .flush      (flush),
  .rn_we      (rn_we),
  .rn_arch    (rn_arch),
  .rn_ptag    (rn_ptag),
  .rs_vld     (rs_vld),
  .rs_mis     (rs_mis),
  .rs_ckpt    (rs_ckpt),
  .rd_arch    (rd_arch),
  .rd_ptag    (rd_ptag),
  .ckpt_avail (ckpt_avail),
  .rec_done   (rec_done),
  .pend_flush (pend_flush),
  .rst_fire   (rst_fire)
);

// File: tb/sim_rename_ckpt_map.sv
`timescale 1ns/1ps
module sim_rename_ckpt_map;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rn_we, cp_req, rt_we, flush;
  logic [4:0]  rn_arch, rt_arch;
  logic [5:0]  rn_ptag, rt_ptag;
  logic [3:0]  cp_bid;
  logic [1:0]  rs_vld, rs_mis, rs_ckpt;
  logic [7:0]  rs_bid;
  logic [9:0]  rd_arch;
  logic [11:0] rd_ptag;
  logic        ckpt_avail, rec_done, pend_flush;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  rename_ckpt_map u0 (
    .clk(clk), .rst_n(rst_n), .rn_we(rn_we), .rn_arch(rn_arch), .rn_ptag(rn_ptag),
    .cp_req(cp_req), .cp_bid(cp_bid), .rs_vld(rs_vld), .rs_mis(rs_mis),
    .rs_ckpt(rs_ckpt), .rs_bid(rs_bid), .rt_we(rt_we), .rt_arch(rt_arch),
    .rt_ptag(rt_ptag), .flush(flush), .rd_arch(rd_arch), .rd_ptag(rd_ptag),
    .ckpt_avail(ckpt_avail), .rec_done(rec_done), .pend_flush(pend_flush)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    rn_we = 0; rn_arch = '0; rn_ptag = '0; cp_req = 0; cp_bid = '0;
    rs_vld = '0; rs_mis = '0; rs_ckpt = '0; rs_bid = '0;
    rt_we = 0; rt_arch = '0; rt_ptag = '0; flush = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic rd_chk(input string req, input int arch, input int exp);
    rd_arch[4:0] = 5'(arch);
    #1;
    check(req, int'(rd_ptag[5:0]), exp);
  endtask

  task automatic do_rn(input int a, input int p);
    rn_we = 1; rn_arch = 5'(a); rn_ptag = 6'(p);
    step();
  endtask

  task automatic do_cp(input int b);
    cp_req = 1; cp_bid = 4'(b);
    step();
  endtask

  task automatic set_res(input int port, input int b, input bit mis, input bit ck);
    rs_vld[port] = 1'b1; rs_mis[port] = mis; rs_ckpt[port] = ck;
    rs_bid[port*4 +: 4] = 4'(b);
  endtask

  task automatic do_flush();
    flush = 1;
    step();
  endtask

  task automatic t_reset();
    check("R1 avail", int'(ckpt_avail), 1);
    check("R1 rec_done", int'(rec_done), 0);
    check("R1 pend", int'(pend_flush), 0);
    rd_chk("R1 map0", 0, 0);
    rd_chk("R1 map31", 31, 31);
    rd_arch[9:5] = 5'd17; #1;
    check("R1 port1 map17", int'(rd_ptag[11:6]), 17);
  endtask

  task automatic t_rename();
    do_rn(5, 40);
    rd_chk("R2 write a5", 5, 40);
    do_rn(6, 41);
    rd_chk("R2 write a6", 6, 41);
    rd_chk("R2 a5 kept", 5, 40);
  endtask

  task automatic t_restore_fill();
    do_cp(1);
    do_rn(5, 50);
    rd_chk("R2 a5 renamed", 5, 50);
    set_res(0, 1, 1, 1);
    rn_we = 1; rn_arch = 5'd7; rn_ptag = 6'd60;
    cp_req = 1; cp_bid = 4'd2;
    step();
    rd_chk("R4 a5 restored", 5, 40);
    check("R4 rec_done pulse", int'(rec_done), 1);
    rd_chk("R4 same-cycle rename ignored", 7, 7);
    step();
    check("R4 rec_done one cycle", int'(rec_done), 0);
    do_cp(3); do_cp(4); do_cp(5);
    check("R3 three slots used", int'(ckpt_avail), 1);
    do_cp(6);
    check("R3 all slots used", int'(ckpt_avail), 0);
    do_cp(7);
    set_res(1, 7, 0, 1);
    step();
    check("R3 request when full ignored", int'(ckpt_avail), 0);
    set_res(0, 4, 0, 1);
    step();
    check("R6 correct frees slot", int'(ckpt_avail), 1);
    rd_chk("R6 map unchanged", 5, 40);
    do_cp(8);
    check("R6 only one slot freed", int'(ckpt_avail), 0);
    do_flush();
    check("R9 flush frees slots", int'(ckpt_avail), 1);
    rd_chk("R9 flush loads committed", 5, 5);
  endtask

  task automatic t_younger();
    do_cp(1); do_rn(8, 20);
    do_cp(2); do_rn(8, 21);
    do_cp(3); do_rn(8, 22);
    rd_chk("R2 a8 last", 8, 22);
    set_res(1, 2, 1, 1);
    step();
    rd_chk("R5 middle restore", 8, 20);
    check("R5 rec_done", int'(rec_done), 1);
    do_cp(4); do_cp(5);
    check("R5 younger freed, one left", int'(ckpt_avail), 1);
    do_cp(6);
    check("R5 three freed", int'(ckpt_avail), 0);
    set_res(0, 3, 1, 1);
    step();
    rd_chk("R7 discarded younger", 8, 20);
    check("R7 no rec_done", int'(rec_done), 0);
    check("R7 slots unchanged", int'(ckpt_avail), 0);
    do_flush();
  endtask

  task automatic t_dual();
    do_cp(1); do_rn(9, 30);
    do_cp(2); do_rn(9, 31);
    set_res(0, 2, 1, 1);
    set_res(1, 1, 1, 1);
    step();
    rd_chk("R7 older wins", 9, 9);
    check("R7 rec_done", int'(rec_done), 1);
    do_flush();
  endtask

  task automatic t_nockpt();
    do_rn(11, 33);
    set_res(1, 9, 1, 0);
    step();
    check("R8 pend set", int'(pend_flush), 1);
    check("R8 no rec_done", int'(rec_done), 0);
    rd_chk("R8 map unchanged", 11, 33);
    step();
    check("R8 pend held", int'(pend_flush), 1);
  endtask

  task automatic t_flush();
    rt_we = 1; rt_arch = 5'd10; rt_ptag = 6'd45;
    step();
    do_rn(10, 46);
    rd_chk("R2 a10", 10, 46);
    do_cp(1);
    flush = 1;
    set_res(0, 1, 1, 1);
    rn_we = 1; rn_arch = 5'd12; rn_ptag = 6'd50;
    step();
    rd_chk("R9 committed a10", 10, 45);
    rd_chk("R9 a11 back", 11, 11);
    rd_chk("R9 rename ignored", 12, 12);
    check("R9 pend cleared", int'(pend_flush), 0);
    check("R9 restore overridden", int'(rec_done), 0);
    do_cp(2); do_cp(3); do_cp(4);
    check("R9 all freed (3 used)", int'(ckpt_avail), 1);
    do_cp(5);
    check("R9 all freed (4 used)", int'(ckpt_avail), 0);
    do_flush();
  endtask

  initial begin
    clear_in();
    rd_arch = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rename();
    t_restore_fill();
    t_younger();
    t_dual();
    t_nockpt();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule